// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Engine

This block is the bit engine of a master-side synchronous serial port. It pulls parallel words from a show-ahead transmit queue and shifts them out on `mosi`. At the same time it assembles the bits arriving on `miso` and hands each finished word to a receive queue. The serial clock `sck` is made from the block clock by a 14-bit divisor. Configuration inputs select the following:
- the idle level of `sck`
- which edge samples the data
- bit order
- word length (8 or 16 bits)
- whether the engine transmits at all

Software-facing registers, chip select and slave operation live elsewhere.

The control is a four-state machine:
- `ST_OFF` is the disabled state.
- `ST_ARMED` is enabled and waiting for a word to be possible.
- `ST_SHIFT` is a word on the wire.
- `ST_RETIRE` is the one cycle in which the finished word is handed over or dropped.

The transitions are:
- *arm*: OFF→ARMED, when `enable` is high.
- *launch*: ARMED→SHIFT, when a word can start.
- *disarm*: ARMED→OFF, when `enable` is low.
- *finish*: SHIFT→RETIRE, on the last `sck` edge.
- *rearm*: RETIRE→ARMED, when `enable` is high.
- *stop*: RETIRE→OFF, when `enable` is low.
- *abort*: any state→OFF, on `soft_rst`.

Top module: `serial_shift_engine`

## Requirements
- R1: While a word is on the wire, `sck` changes level every N block-clock cycles, where N is `cfg_div` and a value of 0 acts as 1. The first change comes N cycles after `busy` rises.
- R2: Whenever no word is on the wire and the engine is enabled, `sck` rests low when `cfg_idle_low`=1 and high when `cfg_idle_low`=0.
- R3: With `cfg_first_edge`=1, data is captured on the 1st, 3rd, 5th … `sck` edge of a word and `mosi` is stable there. With `cfg_first_edge`=0, capture happens on the 2nd, 4th … edge.
- R4: With `cfg_lsb_first`=1, bit 0 travels first on both lines. With 0, the top bit of the word travels first. A received word is delivered on `rx_data` with the first-received bit placed accordingly.
- R5: With `cfg_wide`=1 a word is 16 bits, taking 32 `sck` edges. With 0 a word is 8 bits, taking 16 edges: only `tx_data[7:0]` is sent and `rx_data[15:8]` reads 0. `busy` stays high through the last edge of a word.
- R6: With `cfg_txrx`=1, a word starts only when `tx_empty` is low, and `tx_pop` is high for exactly one cycle per word. Each finished word is offered with a one-cycle `rx_push`.
- R7: With `cfg_txrx`=0 (receive only), `tx_pop` never rises and `mosi` stays 0. Words keep starting while `rx_full` is low and stop once it is high.
- R8: If `rx_full` is high in the cycle a word is retired, `rx_push` stays low and `ovf_pulse` is high for that one cycle.
- R9: In transmit mode with `enable` high, a word retired while `tx_empty` is high raises `udr_pulse` for one cycle. The engine then waits without clocking.
- R10: Lowering `enable` during a word lets that word finish with all its edges. No further word starts, even if transmit data is waiting.
- R11: A one-cycle `soft_rst` drops `busy` and returns `sck` to its idle level at the next clock edge. The aborted word is never pushed.
- R12: After `rst_n` the engine is idle: `busy`, `tx_pop`, `rx_push`, `ovf_pulse` and `udr_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the source of `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous abort; returns the engine to OFF |
| enable | input | 1 | Run control; when low, the current word still finishes |
| cfg_div | input | 14 | Half-period of `sck` in block-clock cycles (0 acts as 1) |
| cfg_idle_low | input | 1 | 1: `sck` idles low; 0: idles high |
| cfg_first_edge | input | 1 | 1: capture on odd edges; 0: capture on even edges |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_wide | input | 1 | 1: 16-bit words; 0: 8-bit words |
| cfg_txrx | input | 1 | 1: transmit and receive; 0: receive only |
| tx_empty | input | 1 | Transmit queue has no word |
| tx_data | input | 16 | Head word of the transmit queue |
| tx_pop | output | 1 | Consume the head transmit word |
| rx_full | input | 1 | Receive queue cannot accept a word |
| rx_data | output | 16 | Assembled received word, valid with `rx_push` |
| rx_push | output | 1 | Write `rx_data` into the receive queue |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is on the wire |
| ovf_pulse | output | 1 | A finished word was dropped for lack of room |
| udr_pulse | output | 1 | Transmit data ran out while a word was due |

## Verification
The hardest situations to reach are those where a word ends under an unusual condition:
- the receive queue filling before the word ends
- `enable` or `soft_rst` changing part-way through the shifting

The bench drives the queues from its own models. A transmit run of three words into a receive queue of capacity one forces two overflow retirements followed by an underrun. The bench's `sck` edge counter times the mid-word disable and the abort, so each lands several edges into a word rather than at a boundary. A sweep over all 32 mode combinations and three small divisors checks every phase, order and width pairing against a bench-side slave model.

// File: rtl/sse_pkg.sv
package sse_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_RETIRE = 2'd3
    } sse_state_e;
endpackage

// File: rtl/sse_clkdiv.sv
module sse_clkdiv #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // a divisor of zero behaves like one
    assign limit = (div_n == '0) ? '0 : div_n - DIV_W'(1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

    // R1: two ticks are never adjacent when the half-period exceeds one cycle
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_n > DIV_W'(1)) |=> (!tick || div_n != $past(div_n)));
endmodule

// File: rtl/sse_shifter.sv
module sse_shifter #(
    parameter int WORD_MAX = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WORD_MAX-1:0] load_word,
    input  logic                shift_out,
    input  logic                sample,
    input  logic                miso,
    input  logic                lsb_first,
    input  logic                wide,
    input  logic                drive,
    output logic                mosi,
    output logic [WORD_MAX-1:0] rx_word
);
    localparam int HALF = WORD_MAX / 2;

    logic [WORD_MAX-1:0] tx_sr, rx_sr, rx_next;

    always_comb begin
        if (lsb_first) begin
            rx_next = rx_sr >> 1;
            if (wide) rx_next[WORD_MAX-1] = miso;
            else      rx_next[HALF-1]     = miso;
        end else begin
            rx_next = {rx_sr[WORD_MAX-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          tx_sr <= '0;
        else if (load)       tx_sr <= load_word;
        else if (shift_out)  tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rx_sr <= '0;
        else if (load)    rx_sr <= '0;
        else if (sample)  rx_sr <= rx_next;
    end

    always_comb begin
        if (!drive)         mosi = 1'b0;
        else if (lsb_first) mosi = tx_sr[0];
        else if (wide)      mosi = tx_sr[WORD_MAX-1];
        else                mosi = tx_sr[HALF-1];
    end

    assign rx_word = rx_sr;
endmodule

// File: rtl/serial_shift_engine.sv
module serial_shift_engine
    import sse_pkg::*;
#(
    parameter int WORD_MAX = 16,
    parameter int DIV_W    = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                enable,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                cfg_idle_low,
    input  logic                cfg_first_edge,
    input  logic                cfg_lsb_first,
    input  logic                cfg_wide,
    input  logic                cfg_txrx,
    input  logic                tx_empty,
    input  logic [WORD_MAX-1:0] tx_data,
    output logic                tx_pop,
    input  logic                rx_full,
    output logic [WORD_MAX-1:0] rx_data,
    output logic                rx_push,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic                busy,
    output logic                ovf_pulse,
    output logic                udr_pulse
);
    localparam int HALF  = WORD_MAX / 2;
    localparam int CNT_W = $clog2(2 * WORD_MAX + 1);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * WORD_MAX - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2 * HALF - 1);

    sse_state_e          state_q, state_d;
    logic [CNT_W-1:0]    edge_q;
    logic                sck_q, tick, run, odd_edge, last_edge;
    logic                start_word, do_sample, do_shift, idle_level;
    logic [WORD_MAX-1:0] rx_word;

    assign idle_level = !cfg_idle_low;
    assign run        = (state_q == ST_SHIFT) && !soft_rst;

    sse_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div_n (cfg_div),
        .tick  (tick)
    );

    // edge_q counts the edges already made in this word
    assign odd_edge   = ~edge_q[0];
    assign last_edge  = tick && (edge_q == (cfg_wide ? LAST_WIDE : LAST_NARROW));
    assign do_sample  = tick && (cfg_first_edge ? odd_edge : !odd_edge);
    assign do_shift   = tick && (cfg_first_edge ? !odd_edge : (odd_edge && edge_q != '0));
    assign start_word = (state_q == ST_ARMED) && enable && !soft_rst &&
                        (cfg_txrx ? !tx_empty : !rx_full);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = ST_OFF;                                  // abort
        end else begin
            unique case (state_q)
                ST_OFF:    if (enable) state_d = ST_ARMED;     // arm
                ST_ARMED:  if (!enable) state_d = ST_OFF;      // disarm
                           else if (start_word) state_d = ST_SHIFT; // launch
                ST_SHIFT:  if (last_edge) state_d = ST_RETIRE; // finish
                ST_RETIRE: state_d = enable ? ST_ARMED : ST_OFF; // rearm / stop
                default:   state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            sck_q  <= 1'b0;
        end else if (state_q != ST_SHIFT || soft_rst) begin
            edge_q <= '0;
            sck_q  <= idle_level;
        end else if (tick) begin
            edge_q <= edge_q + CNT_W'(1);
            sck_q  <= ~sck_q;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_SHIFT);
        tx_pop    = start_word && cfg_txrx;
        rx_push   = (state_q == ST_RETIRE) && !soft_rst && !rx_full;
        ovf_pulse = (state_q == ST_RETIRE) && !soft_rst && rx_full;
        udr_pulse = (state_q == ST_RETIRE) && !soft_rst && enable && cfg_txrx && tx_empty;
    end

    sse_shifter #(.WORD_MAX(WORD_MAX)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_word),
        .load_word (cfg_txrx ? tx_data : '0),
        .shift_out (do_shift),
        .sample    (do_sample),
        .miso      (miso),
        .lsb_first (cfg_lsb_first),
        .wide      (cfg_wide),
        .drive     (cfg_txrx),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    assign rx_data = rx_word;
    assign sck     = sck_q;

    assert_pop_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (!tx_empty && !busy));
    assert_rxonly_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_txrx |-> !tx_pop);
    assert_push_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    assert_ovf_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> !rx_push);
    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !rx_push));
endmodule

// File: tb/serial_shift_engine_bench.sv
`timescale 1ns/1ps
module serial_shift_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n, soft_rst, enable, miso;
    logic [13:0] cfg_div;
    logic        cfg_idle_low, cfg_first_edge, cfg_lsb_first, cfg_wide, cfg_txrx;
    logic        tx_empty, tx_pop, rx_full, rx_push, sck, mosi, busy, ovf_pulse, udr_pulse;
    logic [15:0] tx_data, rx_data;

    int checks = 0, errors = 0, cyc = 0;
    logic [15:0] tx_q [0:7];
    logic [15:0] s_q  [0:7];
    logic [15:0] rx_got [0:7];
    int tx_rd = 0, tx_len = 0, rx_cnt = 0, rx_cap = 4;
    int npop = 0, npush = 0, novf = 0, nudr = 0, wcnt = 0;
    int since = 0, ecnt = 0;
    logic [15:0] capw;
    logic prev_busy = 1'b0, prev_sck = 1'b0, skip_mon = 1'b0;

    always #2 clk = ~clk;

    assign tx_empty = (tx_rd >= tx_len);
    assign tx_data  = tx_q[tx_rd[2:0]];
    assign rx_full  = (rx_cnt >= rx_cap);

    serial_shift_engine u_serial_shift_engine (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
        .cfg_div(cfg_div), .cfg_idle_low(cfg_idle_low), .cfg_first_edge(cfg_first_edge),
        .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide), .cfg_txrx(cfg_txrx),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_data(rx_data), .rx_push(rx_push),
        .sck(sck), .mosi(mosi), .miso(miso), .busy(busy),
        .ovf_pulse(ovf_pulse), .udr_pulse(udr_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int wbits();
        return cfg_wide ? 16 : 8;
    endfunction

    function automatic logic [15:0] wmask();
        return cfg_wide ? 16'hFFFF : 16'h00FF;
    endfunction

    function automatic logic sbit(input int i);
        logic [15:0] s;
        s = s_q[wcnt[2:0]];
        return cfg_lsb_first ? s[i] : s[wbits() - 1 - i];
    endfunction

    // queue models and event counters
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_pop) begin tx_rd <= tx_rd + 1; npop <= npop + 1; end
        if (rx_push) begin rx_got[rx_cnt[2:0]] <= rx_data; rx_cnt <= rx_cnt + 1; npush <= npush + 1; end
        if (ovf_pulse) novf <= novf + 1;
        if (udr_pulse) nudr <= nudr + 1;
    end

    // slave model and line monitor, sampling after the falling clock edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !skip_mon) begin
            int neff;
            neff = (cfg_div == 14'd0) ? 1 : int'(cfg_div);
            since++;
            if (busy && !prev_busy) begin
                since = 0; ecnt = 0; capw = '0;
                if (cfg_first_edge) miso = sbit(0);
            end
            if (sck != prev_sck && (busy || prev_busy)) begin
                ecnt++;
                chk(since == neff, "R1 sck half-period", since, neff);
                since = 0;
                if (cfg_first_edge ? (ecnt % 2 == 1) : (ecnt % 2 == 0)) begin
                    int idx;
                    idx = cfg_first_edge ? (ecnt - 1) / 2 : ecnt / 2 - 1;
                    if (cfg_lsb_first) capw[idx] = mosi;
                    else               capw[wbits() - 1 - idx] = mosi;
                end else if (cfg_first_edge) begin
                    if (ecnt < 2 * wbits()) miso = sbit(ecnt / 2);
                end else begin
                    miso = sbit((ecnt - 1) / 2);
                end
            end
            if (!busy && prev_busy) begin
                logic [15:0] expw;
                expw = cfg_txrx ? (tx_q[wcnt[2:0]] & wmask()) : 16'h0000;
                chk(ecnt == 2 * wbits(), "R5 edges per word", ecnt, 2 * wbits());
                chk(capw == expw, "R3 R4 serial data out", int'(capw), int'(expw));
                wcnt++;
            end
            if (!busy && !prev_busy && enable)
                chk(sck == !cfg_idle_low, "R2 idle level", int'(sck), int'(!cfg_idle_low));
            if (!cfg_txrx)
                chk(mosi == 1'b0, "R7 mosi quiet", int'(mosi), 0);
        end
        prev_busy = busy;
        prev_sck  = sck;
    end

    task automatic setup(input logic il, fe, lb, wd, tr, input int dv, input int ntx, input int cap);
        @(negedge clk);
        enable = 1'b0;
        cfg_idle_low = il; cfg_first_edge = fe; cfg_lsb_first = lb;
        cfg_wide = wd; cfg_txrx = tr; cfg_div = 14'(dv);
        for (int k = 0; k < 8; k++) begin
            tx_q[k] = 16'((32'hA5C3 ^ (k * 32'h1357) ^ (dv * 32'h0101)) + {il, fe, lb, wd, tr});
            s_q[k]  = 16'(32'h3C69 + k * 32'h0F1E + dv * 32'h0033 + {lb, fe, wd, il});
        end
        tx_rd = 0; tx_len = ntx; rx_cnt = 0; rx_cap = cap;
        npop = 0; npush = 0; novf = 0; nudr = 0; wcnt = 0;
        @(negedge clk);
    endtask

    task automatic run_cfg(input logic il, fe, lb, wd, tr, input int dv, input int ntx, input int cap);
        int exp_words, exp_push, exp_ovf;
        setup(il, fe, lb, wd, tr, dv, ntx, cap);
        enable = 1'b1;
        exp_words = tr ? ntx : cap;
        exp_push  = (exp_words < cap) ? exp_words : cap;
        exp_ovf   = (tr && ntx > cap) ? ntx - cap : 0;
        while (wcnt < exp_words) @(negedge clk);
        repeat (8) @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(wcnt == exp_words, tr ? "R6 words sent" : "R7 words received", wcnt, exp_words);
        chk(npop == (tr ? ntx : 0), tr ? "R6 pops" : "R7 no pops", npop, tr ? ntx : 0);
        chk(npush == exp_push, "R6 pushes", npush, exp_push);
        chk(novf == exp_ovf, "R8 overflow pulses", novf, exp_ovf);
        chk(nudr == (tr ? 1 : 0), "R9 underrun pulses", nudr, tr ? 1 : 0);
        for (int k = 0; k < exp_push; k++)
            chk(rx_got[k] == (s_q[k] & wmask()), "R4 R5 received word",
                int'(rx_got[k]), int'(s_q[k] & wmask()));
    endtask

    initial begin
        while (cyc < 190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d expected below %0d", cyc, 190000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; soft_rst = 1'b0; enable = 1'b0; miso = 1'b0;
        cfg_div = 14'd1; cfg_idle_low = 1'b1; cfg_first_edge = 1'b1;
        cfg_lsb_first = 1'b0; cfg_wide = 1'b0; cfg_txrx = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R12 busy after reset", int'(busy), 0);
        chk(tx_pop == 1'b0 && rx_push == 1'b0, "R12 queue strobes after reset", int'({tx_pop, rx_push}), 0);
        chk(ovf_pulse == 1'b0 && udr_pulse == 1'b0, "R12 error pulses after reset", int'({ovf_pulse, udr_pulse}), 0);
        chk(sck == 1'b0, "R2 idle low after reset", int'(sck), 0);

        // sweep every mode combination over three small divisors
        for (int m = 0; m < 32; m++) begin
            for (int d = 0; d < 3; d++) begin
                int dv;
                dv = (d == 0) ? 0 : ((d == 1) ? 1 : 3);
                run_cfg(m[0], m[1], m[2], m[3], m[4], dv, 2, m[4] ? 4 : 2);
            end
        end

        // R8: receive queue with room for one word
        run_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2, 3, 1);
        // R1: a long half-period
        run_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 100, 1, 4);

        // R10: enable dropped in the middle of a word
        setup(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2, 3, 4);
        enable = 1'b1;
        while (!(busy && ecnt >= 5)) @(negedge clk);
        enable = 1'b0;
        chk(busy == 1'b1, "R10 busy held after disable", int'(busy), 1);
        while (busy) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(wcnt == 1 && npop == 1, "R10 single word after disable", wcnt * 16 + npop, 17);
        chk(npush == 1 && busy == 1'b0, "R10 word delivered then idle", npush, 1);

        // R11: abort in the middle of a word
        setup(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3, 3, 4);
        enable = 1'b1;
        while (!(busy && ecnt >= 3)) @(negedge clk);
        skip_mon = 1'b1;
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        enable = 1'b0;
        #1;
        chk(busy == 1'b0, "R11 busy cleared by abort", int'(busy), 0);
        chk(sck == 1'b1, "R11 sck back to idle", int'(sck), 1);
        repeat (10) @(negedge clk);
        chk(npush == 0 && novf == 0, "R11 aborted word not delivered", npush + novf, 0);
        skip_mon = 1'b0;
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule